// File: doc/BRIEF.md
# Byte-Wide Clocked Serial Shift Port

This block moves one byte at a time over three serial pins: a data input, a data output and a shift clock. The shift clock pin works in both directions. When one of three internal rates is selected, the port drives the clock itself. When the external source is selected, the pin becomes an input and a remote master paces the transfer. Software chooses, at the start of each transfer, whether the byte leaves and arrives least significant bit first or most significant bit first.

A two-entry register port gives access to the block. Entry 0 is the data byte: it holds the byte to send, and after a transfer it holds the byte received. Entry 1 is the control word. Writing the control word with its start bit set launches a transfer. The port then clocks out eight bits and samples eight bits, and marks completion with a flag and an optional interrupt.

Top module: `sio_serial_port`

## Requirements
- R1: After reset the following values hold: data reads 0x00, control reads 0x00, `sck_o` is 1, `sck_oe` is 0, `sdo` is 1 and `irq` is 0.
- R2: With control bit 1 clear (LSB first), data bit 0 goes out first and the first bit sampled lands in data bit 0.
- R3: With control bit 1 set (MSB first), data bit 7 goes out first and the first bit sampled lands in data bit 7.
- R4: Control bits 3:2 select the clock source. Values 1, 2 and 3 pick internal clocks whose period is 2*HALF_FAST, 2*HALF_MID and 2*HALF_SLOW system clocks (40, 320 and 1280 by default). In these modes the clock idles high, `sdo` changes after a falling edge, and `sdi` is sampled on a rising edge.
- R5: With control bits 3:2 at 0, `sck_oe` is 0. `sck_i` passes through a two-flop synchroniser, and each synchronised fall and rise shifts out one bit and samples one bit, exactly as in internal mode.
- R6: Writing the control word with bit 0 set while idle sets busy (control bit 6) at once. Busy clears at the eighth rising shift-clock edge, and exactly eight falling and eight rising edges occur.
- R7: At completion, done (control bit 5) sets and the received byte replaces the data entry. `irq` equals done AND enable (control bit 4). Starting a transfer, or writing the control word with bit 5 clear, clears done.
- R8: Writes to the data entry while busy have no effect.
- R9: While busy, control writes leave the bit order and clock select unchanged, and the running transfer completes as it began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 data, 1 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| sck_i | input | 1 | Shift clock pin, input side |
| sck_o | output | 1 | Shift clock pin, output side |
| sck_oe | output | 1 | Shift clock pin drive enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The hardest cases to reach from the ports are register writes that land in the middle of a running transfer. A stray data write or a change of order and rate must leave the bits already on the wire undisturbed. To reach this, the bench acts as the remote end of the link. It counts falling shift-clock edges, and on the third one it fires a data write and a control write that flips both fields. It then checks the wire bits, the received byte and the clock period against an undisturbed transfer. External-clock mode is reached by driving the pin slowly from the bench, with enough spacing that the synchroniser latency stays within each half period.

// File: rtl/sio_pkg.sv
package sio_pkg;
   typedef enum logic [1:0] {
      CLK_EXT  = 2'd0,
      CLK_FAST = 2'd1,
      CLK_MID  = 2'd2,
      CLK_SLOW = 2'd3
   } clk_src_e;

   localparam logic ADDR_DATA = 1'b0;
   localparam logic ADDR_CTRL = 1'b1;

   localparam int CB_START = 0;
   localparam int CB_MSB   = 1;
   localparam int CB_SEL_L = 2;
   localparam int CB_SEL_H = 3;
   localparam int CB_IE    = 4;
   localparam int CB_DONE  = 5;
   localparam int CB_BUSY  = 6;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen
   import sio_pkg::*;
#(
   parameter int HALF_FAST   = 20,
   parameter int HALF_MID    = 160,
   parameter int HALF_SLOW   = 640,
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  clk_src_e sel,
   input  logic     sck_i,
   output logic     sck_o,
   output logic     sck_oe,
   output logic     fall_evt,
   output logic     rise_evt
);
   localparam int HALF_MAX = (HALF_SLOW > HALF_MID) ?
                             ((HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST) :
                             ((HALF_MID > HALF_FAST) ? HALF_MID : HALF_FAST);
   localparam int CW = $clog2(HALF_MAX + 1);

   generate
      if (HALF_FAST < 1 || HALF_MID < 1 || HALF_SLOW < 1) begin : g_bad_half
         $error("sio_clkgen: half periods must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sio_clkgen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // internal divider
   logic [CW-1:0] div_cnt;
   logic [CW-1:0] half_lim;
   logic          sck_q;
   logic          div_wrap;
   logic          use_int;

   assign use_int = (sel != CLK_EXT);

   always_comb begin
      unique case (sel)
         CLK_FAST: half_lim = CW'(HALF_FAST - 1);
         CLK_MID:  half_lim = CW'(HALF_MID - 1);
         CLK_SLOW: half_lim = CW'(HALF_SLOW - 1);
         default:  half_lim = '0;
      endcase
   end

   assign div_wrap = run && use_int && (div_cnt == half_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         sck_q   <= 1'b1;
      end else if (!run || !use_int) begin
         div_cnt <= '0;
         sck_q   <= 1'b1;
      end else if (div_wrap) begin
         div_cnt <= '0;
         sck_q   <= ~sck_q;
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end

   // external synchroniser chain
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_prev;
   logic                   ext_now;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= sck_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b1;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign ext_now = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_prev <= 1'b1;
      else        ext_prev <= ext_now;
   end

   logic ext_fall;
   logic ext_rise;
   assign ext_fall = ext_prev & ~ext_now;
   assign ext_rise = ~ext_prev & ext_now;

   always_comb begin
      if (use_int) begin
         fall_evt = div_wrap & sck_q;
         rise_evt = div_wrap & ~sck_q;
      end else begin
         fall_evt = run & ext_fall;
         rise_evt = run & ext_rise;
      end
   end

   assign sck_o  = sck_q;
   assign sck_oe = use_int;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
   parameter int W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [W-1:0]           load_val,
   input  logic                   start,
   input  logic                   run,
   input  logic                   msb_first,
   input  logic                   fall_evt,
   input  logic                   rise_evt,
   input  logic                   sdi,
   output logic [W-1:0]           data,
   output logic                   sdo,
   output logic [$clog2(W+1)-1:0] bit_cnt,
   output logic                   complete
);
   localparam int BW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_w
         $error("sio_shifter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] sr;
   logic [BW-1:0] cnt;
   logic          out_bit;
   logic [W-1:0]  shifted;

   assign out_bit  = msb_first ? sr[W-1] : sr[0];
   assign shifted  = msb_first ? {sr[W-2:0], sdi} : {sdi, sr[W-1:1]};
   assign complete = run && rise_evt && (cnt == BW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;
      end else if (run && rise_evt) begin
         sr <= shifted;
      end else if (load && !run) begin
         sr <= load_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start || complete) begin
         cnt <= '0;
      end else if (run && rise_evt) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sdo <= 1'b1;
      else if (run && fall_evt)   sdo <= out_bit;
   end

   assign data    = sr;
   assign bit_cnt = cnt;
endmodule

// File: rtl/sio_serial_port.sv
module sio_serial_port
   import sio_pkg::*;
#(
   parameter int HALF_FAST   = 20,
   parameter int HALF_MID    = 160,
   parameter int HALF_SLOW   = 640,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       sck_i,
   output logic       sck_o,
   output logic       sck_oe,
   input  logic       sdi,
   output logic       sdo,
   output logic       irq
);
   localparam int W  = 8;
   localparam int BW = $clog2(W + 1);

   logic     busy_q;
   logic     done_q;
   logic     ie_q;
   logic     msb_q;
   clk_src_e sel_q;

   logic wr_data;
   logic wr_ctrl;
   logic start;
   logic fall_evt;
   logic rise_evt;
   logic complete;
   logic [W-1:0]  shift_data;
   logic [BW-1:0] bit_cnt;

   assign wr_data = wr_en && (addr == ADDR_DATA);
   assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
   assign start   = wr_ctrl && !busy_q && wdata[CB_START];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         ie_q   <= 1'b0;
         msb_q  <= 1'b0;
         sel_q  <= CLK_EXT;
      end else begin
         if (wr_ctrl) begin
            ie_q <= wdata[CB_IE];
            if (!busy_q) begin
               msb_q <= wdata[CB_MSB];
               sel_q <= clk_src_e'(wdata[CB_SEL_H:CB_SEL_L]);
            end
         end
         if (complete) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else if (start) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
         end else if (wr_ctrl && !wdata[CB_DONE]) begin
            done_q <= 1'b0;
         end
      end
   end

   sio_clkgen #(
      .HALF_FAST  (HALF_FAST),
      .HALF_MID   (HALF_MID),
      .HALF_SLOW  (HALF_SLOW),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_clk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy_q),
      .sel     (sel_q),
      .sck_i   (sck_i),
      .sck_o   (sck_o),
      .sck_oe  (sck_oe),
      .fall_evt(fall_evt),
      .rise_evt(rise_evt)
   );

   sio_shifter #(.W(W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_data),
      .load_val (wdata),
      .start    (start),
      .run      (busy_q),
      .msb_first(msb_q),
      .fall_evt (fall_evt),
      .rise_evt (rise_evt),
      .sdi      (sdi),
      .data     (shift_data),
      .sdo      (sdo),
      .bit_cnt  (bit_cnt),
      .complete (complete)
   );

   always_comb begin
      if (addr == ADDR_DATA) begin
         rdata = shift_data;
      end else begin
         rdata           = '0;
         rdata[CB_MSB]   = msb_q;
         rdata[CB_SEL_H:CB_SEL_L] = sel_q;
         rdata[CB_IE]    = ie_q;
         rdata[CB_DONE]  = done_q;
         rdata[CB_BUSY]  = busy_q;
      end
   end

   assign irq = done_q & ie_q;
endmodule

// File: rtl/sio_port_checks.sv
module sio_port_checks
   import sio_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic       irq,
   input logic       sck_o,
   input logic       sck_oe,
   input clk_src_e   sel,
   input logic       rise,
   input logic [7:0] data,
   input logic [3:0] bit_cnt
);
   a_r4_idle_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_o);

   a_r5_ext_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == CLK_EXT) |-> !sck_oe);

   a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rise) |=> $stable(data));

   a_r6_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r7_done_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt < 4'd8);

   a_r7_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);

   a_r9_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sel));
endmodule

bind sio_serial_port sio_port_checks u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy_q),
   .done   (done_q),
   .irq    (irq),
   .sck_o  (sck_o),
   .sck_oe (sck_oe),
   .sel    (sel_q),
   .rise   (rise_evt),
   .data   (shift_data),
   .bit_cnt(bit_cnt)
);

// File: tb/tb_sio_serial_port.sv
module tb_sio_serial_port;
   localparam int HF = 20, HM = 160, HS = 640;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic sck_i = 1'b1;
   logic sck_o, sck_oe, sdo, irq;
   logic sdi = 1'b1;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   sio_serial_port dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
      .sdi(sdi), .sdo(sdo), .irq(irq)
   );

   // {sel[1:0], msb, tx[7:0], rx[7:0], ie}
   localparam int NV = 6;
   localparam logic [19:0] VEC [NV] = '{
      {2'd1, 1'b0, 8'hA5, 8'h3C, 1'b1},
      {2'd1, 1'b1, 8'hA5, 8'h3C, 1'b1},
      {2'd1, 1'b1, 8'h01, 8'h80, 1'b0},
      {2'd2, 1'b0, 8'h96, 8'hC3, 1'b1},
      {2'd3, 1'b1, 8'h5A, 8'hE7, 1'b0},
      {2'd1, 1'b0, 8'hFF, 8'h00, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = 1'b1;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
      addr = 1'b1;
   endtask

   function automatic int half_of(input logic [1:0] s);
      return (s == 2'd1) ? HF : (s == 2'd2) ? HM : HS;
   endfunction

   // internal-clock transfer; bench acts as the remote end
   task automatic xfer_int(input logic [1:0] sel, input logic msb, input logic [7:0] tx,
                           input logic [7:0] rx, input logic ie, input bit inject,
                           output logic [7:0] got, output int falls, output int rises,
                           output int period);
      logic prev, cur;
      int t_f0, t_f1, cyc, guard;
      logic [7:0] c;
      got = '0; falls = 0; rises = 0; period = 0; t_f0 = 0; t_f1 = 0; cyc = 0;
      wr(1'b0, tx);
      wr(1'b1, {3'b000, ie, sel, msb, 1'b1});
      rd(1'b1, c);
      chk("R6 busy after start", c[6], 1'b1);
      addr = 1'b1;
      prev = sck_o;
      guard = 0;
      while (rdata[6] && guard < 30000) begin
         @(negedge clk);
         cyc++; guard++;
         cur = sck_o;
         if (inject && falls == 3 && wr_en) begin
            if (addr == 1'b0) begin addr = 1'b1; wdata = {3'b000, ie, ~sel, ~msb, 1'b1}; end
            else begin wr_en = 1'b0; addr = 1'b1; end
         end
         if (prev && !cur) begin
            falls++;
            if (falls == 1) t_f0 = cyc;
            if (falls == 2) t_f1 = cyc;
            if (falls <= 8) sdi = rx[msb ? 8 - falls : falls - 1];
            if (inject && falls == 3) begin wr_en = 1'b1; addr = 1'b0; wdata = 8'hFF; end
         end else if (!prev && cur) begin
            if (rises < 8) got[msb ? 7 - rises : rises] = sdo;
            rises++;
         end
         prev = cur;
         #1;
      end
      period = t_f1 - t_f0;
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] c, d, got;
      int f, r, p;

      repeat (3) @(negedge clk);
      // R1 reset state
      rd(1'b0, d); chk("R1 data reset", d, 8'h00);
      rd(1'b1, c); chk("R1 ctrl reset", c, 8'h00);
      chk("R1 sck_o idle", sck_o, 1'b1);
      chk("R1 sck_oe", sck_oe, 1'b0);
      chk("R1 sdo idle", sdo, 1'b1);
      chk("R1 irq", irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [1:0] vs; logic vm, vie; logic [7:0] vt, vr;
         {vs, vm, vt, vr, vie} = VEC[i];
         xfer_int(vs, vm, vt, vr, vie, 1'b0, got, f, r, p);
         chk(vm ? "R3 msb-first tx bits" : "R2 lsb-first tx bits", got, vt);
         rd(1'b0, d);
         chk(vm ? "R3 msb-first rx byte" : "R2 lsb-first rx byte", d, vr);
         chk("R4 sck period", p, 2 * half_of(vs));
         chk("R6 falling edges", f, 8);
         chk("R6 rising edges", r, 8);
         rd(1'b1, c);
         chk("R7 done set", c[5], 1'b1);
         chk("R6 busy clear", c[6], 1'b0);
         chk("R7 irq follows enable", irq, vie);
         chk("R4 sck idle high", sck_o, 1'b1);
      end

      // R7 done clear by writing bit5 = 0, enable kept
      wr(1'b1, 8'h10);
      rd(1'b1, c);
      chk("R7 done cleared", c[5], 1'b0);
      chk("R7 irq cleared", irq, 1'b0);

      // R8 / R9 mid-transfer writes
      xfer_int(2'd1, 1'b0, 8'hC6, 8'h2B, 1'b1, 1'b1, got, f, r, p);
      chk("R9 tx bits unchanged by ctrl write", got, 8'hC6);
      rd(1'b0, d);
      chk("R8 data write ignored", d, 8'h2B);
      chk("R9 period unchanged", p, 2 * HF);
      rd(1'b1, c);
      chk("R9 sel unchanged", c[3:2], 2'd1);
      chk("R9 order unchanged", c[1], 1'b0);

      // R5 external clock
      wr(1'b0, 8'h4D);
      wr(1'b1, 8'h01);
      chk("R5 sck_oe low", sck_oe, 1'b0);
      got = '0;
      for (int b = 0; b < 8; b++) begin
         sck_i = 1'b0;
         repeat (8) @(negedge clk);
         sdi = b[0] ? 1'b1 : 1'b0;   // rx = 0xAA, LSB first
         got[b] = sdo;
         sck_i = 1'b1;
         repeat (8) @(negedge clk);
      end
      chk("R5 ext tx bits", got, 8'h4D);
      rd(1'b1, c);
      chk("R5 ext busy clear", c[6], 1'b0);
      chk("R5 ext done", c[5], 1'b1);
      rd(1'b0, d);
      chk("R5 ext rx byte", d, 8'hAA);

      // R8 data write when idle takes effect
      wr(1'b0, 8'h77);
      rd(1'b0, d);
      chk("R8 idle data write", d, 8'h77);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule